// File: doc/BRIEF.md
# Indirect-Access Forwarding Table Store

This block holds a table of 68-bit forwarding entries (address, VLAN and mixed records) that software never addresses directly. All access goes through a small register window on a simple bus with address, write data, write enable and read data. Three 32-bit data words act as a staging buffer. A single control register takes an entry index and a commit flag.

To read an entry, software writes the index to the control register with the commit flag clear. The selected entry is copied into the data words and can be read on the following cycle. To write an entry, software fills the data words first, then writes the index with the commit flag set. The words are stored in reversed order: the first data word carries the four top bits of the entry and the last carries the lowest 32 bits. A clear input empties the whole table in one cycle, so every entry becomes the free type. The entry count and the revision numbers are parameters.

Top module: `fwd_tbl_window`

## Requirements
- R1: Byte addresses: 0x00 identification, 0x20 control, 0x34 data word 0, 0x38 data word 1, 0x3C data word 2. Read data follows the address in the same cycle. The control register and every unmapped address read as zero.
- R2: Entry bits 67:64 sit in data word 0 bits 3:0, bits 63:32 in word 1 and bits 31:0 in word 2. Data word 0 bits 31:4 always read zero, and values written to them are dropped.
- R3: Writing the control register with bit 31 = 0 and an index (bits 30:0) below the entry count copies that entry into the three data words. The new contents are readable from the cycle after the write.
- R4: Writing the control register with bit 31 = 1 and an in-range index stores the three data words into that entry. The data words themselves keep their values.
- R5: When the index in bits 30:0 is at or above the entry count, a commit changes no entry, including entries whose index matches the low bits, and a select loads all-zero data words.
- R6: The identification register reads {16'h0, major revision, minor revision}. Writes to it have no effect.
- R7: After reset, and after a one-cycle pulse on the clear input, every entry reads as all zeros, which is the free type. Clear does not touch the data words. Clear wins over a commit in the same cycle.
- R8: A data word changes only on a select or on a bus write to that word's own address. Writes to any other address leave it unchanged.
- R9: The entry type field, entry bits 61:60 (word 1 bits 29:28), keeps each code unchanged: 0 free, 1 address, 2 VLAN, 3 VLAN plus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | One-cycle pulse that empties the whole table |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The assertions assume that the bus carries at most one access per cycle and that reg_we is a single-cycle strobe. They also assume that clr_i never stays high through a select whose result is being checked. The bench drives all inputs on the falling edge and holds each write strobe for exactly one cycle. It pulses clear only between bus transactions, except in the one directed case that tests clear and commit in the same cycle. Random indices run a few values past the entry count so that the out-of-range paths are exercised without breaking those assumptions.

// File: rtl/fwd_tbl_pkg.sv
package fwd_tbl_pkg;
  localparam int ENTRY_W  = 68;
  localparam int WORD_W   = 32;
  localparam int NWORDS   = 3;
  localparam int HI_W     = ENTRY_W - 2 * WORD_W;
  localparam int ADDR_W   = 8;
  localparam int COMMIT_B = 31;

  localparam logic [ADDR_W-1:0] A_IDENT = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] A_WORD0 = 8'h34;

  typedef logic [NWORDS-1:0][WORD_W-1:0] word_set_t;

  // word 0 carries the top slice, word 2 the bottom slice
  function automatic logic [ENTRY_W-1:0] join_words(input word_set_t w);
    return {w[0][HI_W-1:0], w[1], w[2]};
  endfunction

  function automatic logic [WORD_W-1:0] slice_word(input logic [ENTRY_W-1:0] e,
                                                   input int k);
    logic [WORD_W-1:0] r;
    case (k)
      0:       r = {{(WORD_W-HI_W){1'b0}}, e[ENTRY_W-1 -: HI_W]};
      1:       r = e[2*WORD_W-1 -: WORD_W];
      default: r = e[WORD_W-1:0];
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] top_mask();
    return {{(WORD_W-HI_W){1'b0}}, {HI_W{1'b1}}};
  endfunction
endpackage

// File: rtl/fwd_tbl_regdec.sv
module fwd_tbl_regdec
  import fwd_tbl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit_ident,
  output logic              hit_ctrl,
  output logic [NWORDS-1:0] hit_word,
  output logic              we_ctrl,
  output logic [NWORDS-1:0] we_word
);
  assign hit_ident = (addr == A_IDENT);
  assign hit_ctrl  = (addr == A_CTRL);
  assign we_ctrl   = we & hit_ctrl;

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    localparam logic [ADDR_W-1:0] OFS = A_WORD0 + ADDR_W'(4 * k);
    assign hit_word[k] = (addr == OFS);
    assign we_word[k]  = we & hit_word[k];
  end
endmodule

// File: rtl/fwd_tbl_array.sv
module fwd_tbl_array
  import fwd_tbl_pkg::*;
#(
  parameter int N     = 24,
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  logic [ENTRY_W-1:0] mem [N];
  logic               any_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < N)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_idx) < N) ? mem[rd_idx] : '0;

  always_comb begin
    any_set = 1'b0;
    for (int i = 0; i < N; i++) any_set = any_set | (|mem[i]);
  end

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any_set);
endmodule

// File: rtl/fwd_tbl_wordbank.sv
module fwd_tbl_wordbank
  import fwd_tbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ENTRY_W-1:0] load_data,
  input  logic [NWORDS-1:0]  wr_word,
  input  logic [WORD_W-1:0]  wdata,
  output word_set_t          words
);
  for (genvar k = 0; k < NWORDS; k++) begin : g_w
    localparam logic [WORD_W-1:0] KEEP = (k == 0) ? top_mask() : '1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          words[k] <= '0;
      else if (load)       words[k] <= slice_word(load_data, k);
      else if (wr_word[k]) words[k] <= wdata & KEEP;
    end
  end

  p_words_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && wr_word == '0) |=> $stable(words));
  p_top_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    words[0][WORD_W-1:HI_W] == '0);
endmodule

// File: rtl/fwd_tbl_window.sv
module fwd_tbl_window
  import fwd_tbl_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [7:0]  REV_MAJOR   = 8'h01,
  parameter logic [7:0]  REV_MINOR   = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_we,
  output logic [31:0] reg_rdata
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [WORD_W-1:0] IDENT = {16'h0, REV_MAJOR, REV_MINOR};

  logic              hit_ident, hit_ctrl, we_ctrl;
  logic [NWORDS-1:0] hit_word, we_word;
  logic [30:0]       ctl_idx;
  logic              idx_ok, sel_go, commit_go;
  logic [ENTRY_W-1:0] arr_rd, load_data;
  word_set_t         words;

  fwd_tbl_regdec u_dec (
    .addr(reg_addr), .we(reg_we),
    .hit_ident(hit_ident), .hit_ctrl(hit_ctrl), .hit_word(hit_word),
    .we_ctrl(we_ctrl), .we_word(we_word)
  );

  // index decode shared by select and commit
  assign ctl_idx   = reg_wdata[30:0];
  assign idx_ok    = (ctl_idx < 31'(NUM_ENTRIES));
  assign sel_go    = we_ctrl & ~reg_wdata[COMMIT_B];
  assign commit_go = we_ctrl &  reg_wdata[COMMIT_B];
  assign load_data = idx_ok ? arr_rd : '0;

  fwd_tbl_array #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .clr(clr_i),
    .wr_en(commit_go & idx_ok), .wr_idx(ctl_idx[IDX_W-1:0]),
    .wr_data(join_words(words)),
    .rd_idx(ctl_idx[IDX_W-1:0]), .rd_data(arr_rd)
  );

  fwd_tbl_wordbank u_bank (
    .clk(clk), .rst_n(rst_n), .load(sel_go), .load_data(load_data),
    .wr_word(we_word), .wdata(reg_wdata), .words(words)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_ident) reg_rdata = IDENT;
    for (int k = 0; k < NWORDS; k++)
      if (hit_word[k]) reg_rdata = words[k];
  end

  p_sel_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_go && idx_ok) |=> join_words(words) == $past(arr_rd));
  p_oob_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_go && !idx_ok) |=> words == '0);
  p_commit_keeps_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> $stable(words));
  p_ident_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ident |-> reg_rdata == IDENT);
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ident && hit_word == '0) |-> reg_rdata == '0);
endmodule

// File: tb/fwd_tbl_window_bench.sv
module fwd_tbl_window_bench;
  localparam int N = 24;
  localparam logic [31:0] ID_EXP = 32'h0000_0103;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  logic [67:0] mdl [N];
  logic [31:0] mw [3];

  always #2.5 clk = ~clk;

  fwd_tbl_window #(.NUM_ENTRIES(N), .REV_MAJOR(8'h01), .REV_MINOR(8'h03)) u_fwd_tbl_window (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] waddr(input int k);
    return 8'h34 + 8'(k * 4);
  endfunction

  function automatic logic [31:0] exp_word(input logic [67:0] e, input int k);
    if (k == 0) return {28'h0, e[67:64]};
    if (k == 1) return e[63:32];
    return e[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // bench-side model of each operation
  task automatic do_word(input int k, input logic [31:0] d);
    bus_wr(waddr(k), d);
    mw[k] = (k == 0) ? {28'h0, d[3:0]} : d;
  endtask

  task automatic do_commit(input logic [30:0] idx);
    bus_wr(8'h20, {1'b1, idx});
    if (idx < N) mdl[idx] = {mw[0][3:0], mw[1], mw[2]};
  endtask

  task automatic do_select(input logic [30:0] idx);
    bus_wr(8'h20, {1'b0, idx});
    for (int k = 0; k < 3; k++) mw[k] = (idx < N) ? exp_word(mdl[idx], k) : 32'h0;
  endtask

  task automatic check_words(input string req);
    logic [31:0] v;
    for (int k = 0; k < 3; k++) begin
      bus_rd(waddr(k), v);
      check(req, v, mw[k]);
    end
  endtask

  task automatic scan_table(input string req);
    for (int i = 0; i < N; i++) begin
      do_select(31'(i));
      check_words(req);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) mdl[i] = '0;
    for (int k = 0; k < 3; k++) mw[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state and register map
    bus_rd(8'h00, v); check("R6 ident", v, ID_EXP);
    bus_rd(8'h20, v); check("R1 ctrl reads zero", v, 32'h0);
    bus_rd(8'h10, v); check("R1 unmapped", v, 32'h0);
    check_words("R1 words after reset");
    scan_table("R7 table empty after reset");

    // R2 top word masking
    do_word(0, 32'hFFFF_FFFF);
    bus_rd(waddr(0), v); check("R2 word0 upper bits", v, 32'h0000_000F);
    do_word(1, 32'hDEAD_BEEF);
    do_word(2, 32'h1234_5678);
    do_commit(31'd5);
    check_words("R4 words kept after commit");
    do_select(31'd0); check_words("R3 select empty entry");
    do_select(31'd5); check_words("R3 select written entry");
    bus_rd(waddr(1), v); check("R2 word1 middle slice", v, 32'hDEAD_BEEF);

    // R9 entry type codes
    for (int t = 0; t < 4; t++) begin
      do_word(0, 32'h0000_0009);
      do_word(1, {2'b01, 2'(t), 28'h0ABCDEF});
      do_word(2, 32'(t) * 32'h1111_1111);
      do_commit(31'(10 + t));
    end
    for (int t = 0; t < 4; t++) begin
      do_select(31'(10 + t));
      bus_rd(waddr(1), v);
      check("R9 type field", 32'(v[29:28]), 32'(t));
    end

    // R5 out of range
    do_word(0, 32'h5); do_word(1, 32'hAAAA_5555); do_word(2, 32'h0F0F_F0F0);
    do_commit(31'd24);
    do_commit(31'd32);
    do_commit(31'h7FFF_FFFF);
    do_select(31'd24); check_words("R5 oob select zero");
    scan_table("R5 oob commit ignored");

    // R8 and R6: writes elsewhere leave words and ident alone
    do_select(31'd5);
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'h1357_9BDF);
    bus_wr(8'h30, 32'h2468_ACE0);
    check_words("R8 words stable");
    bus_rd(8'h00, v); check("R6 ident after write", v, ID_EXP);
    do_word(2, 32'hCAFE_F00D);
    check_words("R8 only word2 changed");

    // R7 clear pulse, words untouched
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    check_words("R7 clear keeps words");
    // clear together with commit
    do_word(0, 32'h3);
    @(negedge clk);
    reg_addr = 8'h20; reg_wdata = {1'b1, 31'd7}; reg_we = 1'b1; clr_i = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; clr_i = 1'b0;
    scan_table("R7 table empty after clear");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op; int k; logic [30:0] idx;
      op  = int'($urandom % 4);
      k   = int'($urandom % 3);
      idx = 31'($urandom % 30);
      case (op)
        0: do_word(k, $urandom);
        1: do_commit(idx);
        2: begin do_select(idx); check_words("R3 random select"); end
        default: begin bus_rd(waddr(k), v); check("R8 random word read", v, mw[k]); end
      endcase
    end
    scan_table("R4 final table contents");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule